// File: doc/BRIEF.md
# ADC Scan-Mode Sequencing Controller

This controller steps an external analog-to-digital converter through a repeating scan of input channels. The channels are arranged in groups of four. A mode field selects how many groups the scan covers, and a count field selects how many leading channels of each group are converted. While the start bit stays 1, the block issues a start pulse with a channel number, waits for the converter's done pulse and stores the returned result word in that channel's result register. It then moves to the next selected channel in the following cycle. When it reaches the end of the last group, it goes back to channel 0.

At the end of every group a completion flag is raised, and an interrupt request follows it when interrupts are enabled. Software clears the flag by reading it while it is 1 and then writing 0. A DMA acknowledge clears the flag directly. When software clears the start bit, the current conversion is allowed to finish, its result is thrown away and the block goes idle. The next start always begins at channel 0.

The state machine has four states. ST_IDLE leads to ST_LAUNCH when the start bit is 1 and the mode is not 00. ST_LAUNCH pulses the converter start and leads to ST_WAIT; if the start bit is 0 it returns to ST_IDLE instead. In ST_WAIT, a done pulse with the start bit at 1 stores the result and leads back to ST_LAUNCH with the next channel. A done pulse with the start bit at 0 discards the result and leads to ST_IDLE. The start bit falling without a done pulse leads to ST_DRAIN. In ST_DRAIN the block waits for the pending done pulse, then discards the result and returns to ST_IDLE.

Top module: `adc_scan_ctrl`

## Requirements
- R1: The mode field sets the scan length. 01 covers channels 0–3, 10 covers 0–7 and 11 covers 0–11. With mode 00, no conversion is ever started.
- R2: Conversions run in ascending channel order, and channel number = 4·group + index. The first conversion after a start is channel 0.
- R3: A count field value k (0–3) selects indices 0..k of each group. Higher indices are skipped, so k=2 in mode 10 gives the order 0,1,2,4,5,6.
- R4: When a done pulse is accepted, the result word goes into the result register of the channel being converted. The next start pulse is issued in the following cycle. Each start pulse lasts one cycle.
- R5: The completion flag reads 1 from the clock edge on which the done pulse of the last selected channel of a group is accepted.
- R6: After the last group, the scan repeats from channel 0 for as long as the start bit is 1. The start bit changes only through a software write.
- R7: After the start bit is written to 0 and then to 1 again, the scan resumes at channel 0, not at the channel where it stopped.
- R8: If the start bit is 0 while a conversion is pending, the block waits for the done pulse, writes no result register, and issues no further start until the start bit is written to 1 again.
- R9: A read of the flag while it is 1 arms the clear. A following write of 0 clears the flag and disarms. A write of 0 without arming leaves the flag at 1.
- R10: A DMA acknowledge clears the flag at the next edge. Clearing the flag by any means also disarms the clear.
- R11: The interrupt request is registered. It equals the new flag value AND the interrupt enable, so it changes on the same edge as the flag. A flag set in the same cycle as a clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Scan length select (00 off, 01/10/11 = 1/2/3 groups) |
| cnt_sel_i | input | 2 | Highest converted index within each group |
| start_wr_i | input | 1 | Write strobe for the start bit |
| start_wdata_i | input | 1 | Value written to the start bit |
| irq_en_i | input | 1 | Interrupt enable |
| flag_rd_i | input | 1 | Software read of the completion flag |
| flag_wr0_i | input | 1 | Software write of 0 to the completion flag |
| dma_ack_i | input | 1 | DMA acknowledge, clears the flag |
| conv_start_o | output | 1 | One-cycle converter start pulse |
| conv_ch_o | output | 4 | Channel number for the conversion |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | 10 | Converter result word, valid with done |
| rd_ch_i | input | 4 | Result register select for readback |
| rd_data_o | output | 10 | Selected result register |
| start_o | output | 1 | Current start bit |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions matter. The completion flag can be set and cleared in the same cycle, and a stop can coincide with a pending conversion or with its done pulse. The flag collision is provoked by holding DMA acknowledge high across several group ends, so that each set meets a clear. The stop collision is provoked by writing the start bit to 0 right after a start pulse, and also in the cycle of a done pulse. A behavioural model in the bench tracks the expected flag, interrupt and start-bit values, the next expected channel and every result register. Those values are compared against the ports on every clock, which confirms that the set wins over the clear, that no result is written for an aborted conversion, and that the scan restarts at channel 0.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_DRAIN
    } scan_state_t;
endpackage

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int GRP_SIZE = 4,
    parameter int NUM_GRP  = 3,
    localparam int IDX_W   = $clog2(GRP_SIZE),
    localparam int GRP_W   = $clog2(NUM_GRP),
    localparam int CH_W    = $clog2(GRP_SIZE * NUM_GRP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_q,
    input  logic [1:0]       mode_i,
    input  logic [IDX_W-1:0] cnt_sel_i,
    input  logic             conv_done_i,
    output logic             conv_start_o,
    output logic [CH_W-1:0]  conv_ch_o,
    output logic             res_we_o,
    output logic             grp_done_o
);
    scan_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [GRP_W-1:0] grp_q, grp_d;
    logic             idx_last, grp_last, accept;

    assign idx_last = (idx_q >= cnt_sel_i);
    assign grp_last = ((int'(grp_q) + 1) >= int'(mode_i));
    assign accept   = (state_q == ST_WAIT) && conv_done_i && start_q;

    // next-state and channel pointer
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        grp_d   = grp_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                grp_d = '0;
                if (start_q && (mode_i != 2'b00)) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                if (start_q) begin
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                    grp_d   = '0;
                end
            end
            ST_WAIT: begin
                if (conv_done_i) begin
                    if (start_q) begin
                        state_d = ST_LAUNCH;
                        if (idx_last) begin
                            idx_d = '0;
                            grp_d = grp_last ? '0 : grp_q + 1'b1;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end else begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                        grp_d   = '0;
                    end
                end else if (!start_q) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (conv_done_i) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                    grp_d   = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            grp_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            grp_q   <= grp_d;
        end
    end

    // outputs
    always_comb begin
        conv_start_o = 1'b0;
        res_we_o     = 1'b0;
        grp_done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LAUNCH: conv_start_o = start_q;
            ST_WAIT: begin
                res_we_o   = accept;
                grp_done_o = accept && idx_last;
            end
            ST_DRAIN:  ;
            default:   ;
        endcase
    end

    assign conv_ch_o = CH_W'(grp_q) * CH_W'(GRP_SIZE) + CH_W'(idx_q);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o); // R4
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (idx_q <= cnt_sel_i)); // R3
    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (conv_ch_o == '0)); // R7
    AST_DRAIN_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && conv_done_i) |=> (!conv_start_o && state_q == ST_IDLE)); // R8
    AST_NO_START_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && mode_i == 2'b00) |=> !conv_start_o); // R1
endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
    parameter int NUM_CH = 12,
    parameter int RES_W  = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CH_W-1:0]  wr_ch_i,
    input  logic [RES_W-1:0] wr_data_i,
    input  logic [CH_W-1:0]  rd_ch_i,
    output logic [RES_W-1:0] rd_data_o
);
    logic [RES_W-1:0] res_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_res
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                res_q[c] <= '0;
            else if (we_i && (wr_ch_i == CH_W'(c)))
                res_q[c] <= wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (rd_ch_i == CH_W'(c)) rd_data_o = res_q[c];
    end
endmodule

// File: rtl/adc_scan_flag.sv
module adc_scan_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr0_i,
    input  logic dma_ack_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q, armed_q, irq_q;
    logic clr, flag_d, armed_d;

    assign clr    = (wr0_i && armed_q) || dma_ack_i;
    assign flag_d = set_i || (flag_q && !clr);

    always_comb begin
        armed_d = armed_q;
        if (wr0_i)
            armed_d = 1'b0;
        else if (rd_i && flag_q)
            armed_d = 1'b1;
        if (!flag_d)
            armed_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            armed_q <= armed_d;
            irq_q   <= flag_d && irq_en_i;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = irq_q;

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q); // R11
    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o); // R11
    AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack_i && !set_i) |=> !flag_q); // R10
    AST_UNARMED_WR0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && wr0_i && !armed_q && !dma_ack_i) |=> flag_q); // R9
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
    parameter int GRP_SIZE = 4,
    parameter int NUM_GRP  = 3,
    parameter int RES_W    = 10,
    localparam int NUM_CH  = GRP_SIZE * NUM_GRP,
    localparam int IDX_W   = $clog2(GRP_SIZE),
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [IDX_W-1:0] cnt_sel_i,
    input  logic             start_wr_i,
    input  logic             start_wdata_i,
    input  logic             irq_en_i,
    input  logic             flag_rd_i,
    input  logic             flag_wr0_i,
    input  logic             dma_ack_i,
    output logic             conv_start_o,
    output logic [CH_W-1:0]  conv_ch_o,
    input  logic             conv_done_i,
    input  logic [RES_W-1:0] conv_data_i,
    input  logic [CH_W-1:0]  rd_ch_i,
    output logic [RES_W-1:0] rd_data_o,
    output logic             start_o,
    output logic             flag_o,
    output logic             irq_o
);
    logic start_q;
    logic res_we, grp_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            start_q <= 1'b0;
        else if (start_wr_i)
            start_q <= start_wdata_i;
    end

    assign start_o = start_q;

    adc_scan_seq #(.GRP_SIZE(GRP_SIZE), .NUM_GRP(NUM_GRP)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_q      (start_q),
        .mode_i       (mode_i),
        .cnt_sel_i    (cnt_sel_i),
        .conv_done_i  (conv_done_i),
        .conv_start_o (conv_start_o),
        .conv_ch_o    (conv_ch_o),
        .res_we_o     (res_we),
        .grp_done_o   (grp_done)
    );

    adc_scan_results #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (res_we),
        .wr_ch_i   (conv_ch_o),
        .wr_data_i (conv_data_i),
        .rd_ch_i   (rd_ch_i),
        .rd_data_o (rd_data_o)
    );

    adc_scan_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (grp_done),
        .rd_i      (flag_rd_i),
        .wr0_i     (flag_wr0_i),
        .dma_ack_i (dma_ack_i),
        .irq_en_i  (irq_en_i),
        .flag_o    (flag_o),
        .irq_o     (irq_o)
    );

    AST_START_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !start_wr_i |=> $stable(start_q)); // R6
endmodule

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int NCH        = 12;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [1:0] cnt_sel = 2'b00;
    logic       start_wr = 1'b0, start_wdata = 1'b0;
    logic       irq_en = 1'b0, flag_rd = 1'b0, flag_wr0 = 1'b0, dma_ack = 1'b0;
    logic       conv_start;
    logic [3:0] conv_ch;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic [3:0] rd_ch = '0;
    logic [9:0] rd_data;
    logic       start_o, flag_o, irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cnt_sel_i(cnt_sel),
        .start_wr_i(start_wr), .start_wdata_i(start_wdata), .irq_en_i(irq_en),
        .flag_rd_i(flag_rd), .flag_wr0_i(flag_wr0), .dma_ack_i(dma_ack),
        .conv_start_o(conv_start), .conv_ch_o(conv_ch), .conv_done_i(conv_done),
        .conv_data_i(conv_data), .rd_ch_i(rd_ch), .rd_data_o(rd_data),
        .start_o(start_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    int n_cmp = 0, n_bad = 0;
    int cyc = 0;
    bit done_run = 0;

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // converter responder: done LAT cycles after start, data = {ch, seq}
    int       resp_cnt = 0;
    logic [3:0] resp_ch = '0;
    logic [5:0] seq = '0;
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (resp_cnt > 0) begin
            resp_cnt <= resp_cnt - 1;
            if (resp_cnt == 1) begin
                conv_done <= 1'b1;
                conv_data <= {resp_ch, seq};
                seq <= seq + 1'b1;
            end
        end
        if (conv_start) begin
            resp_cnt <= LAT;
            resp_ch  <= conv_ch;
        end
    end

    // behavioural reference model
    int   exp_ch = 0;
    bit   start_e = 0, flag_e = 0, armed_e = 0, irq_e = 0;
    bit   inflight = 0, aborted = 0, launch_due = 0;
    int   infl_ch = 0;
    int   res_e [NCH];
    int   n_conv = 0, n_sets = 0;
    int   first_ch = -1;

    always @(posedge clk) begin
        bit set_now, clr, fl_new;
        set_now = 0;
        if (!rst_n) begin
            exp_ch = 0; start_e = 0; flag_e = 0; armed_e = 0; irq_e = 0;
            inflight = 0; aborted = 0; launch_due = 0;
            for (int i = 0; i < NCH; i++) res_e[i] = 0;
        end else begin
            if (inflight) begin
                if (!start_e) aborted = 1;
                if (conv_done) begin
                    if (!aborted) begin
                        int idx, grp;
                        res_e[infl_ch] = int'(conv_data);
                        idx = exp_ch % 4; grp = exp_ch / 4;
                        if (idx == int'(cnt_sel)) begin
                            set_now = 1;
                            idx = 0;
                            grp = (grp + 1 >= int'(mode)) ? 0 : grp + 1;
                        end else idx = idx + 1;
                        exp_ch = grp * 4 + idx;
                        launch_due = 1;
                    end
                    inflight = 0; aborted = 0;
                end
            end
            clr = (flag_wr0 && armed_e) || dma_ack;
            fl_new = set_now || (flag_e && !clr);
            if (flag_wr0) armed_e = 0;
            else if (flag_rd && flag_e) armed_e = 1;
            if (!fl_new) armed_e = 0;
            flag_e = fl_new;
            irq_e = fl_new && irq_en;
            if (set_now) n_sets++;
            if (start_wr) start_e = start_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            cmp("R6 start bit", start_o, start_e);
            cmp("R5/R9/R10 flag", flag_o, flag_e);
            cmp("R11 irq", irq_o, irq_e);
            cmp("R4 result register", rd_data, res_e[rd_ch]);
            if (launch_due) begin
                cmp("R4 back-to-back start", conv_start, start_e);
                launch_due = 0;
            end
            if (!start_e && !inflight) exp_ch = 0;
            if (conv_start) begin
                cmp("R2/R3 channel order", conv_ch, exp_ch);
                cmp("R8 start only when enabled and free", int'(start_e && !inflight), 1);
                if (first_ch < 0) first_ch = conv_ch;
                inflight = 1;
                infl_ch = conv_ch;
                n_conv++;
            end
            rd_ch = (int'(rd_ch) + 1 >= NCH) ? 4'd0 : rd_ch + 1'b1;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done_run) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            summary();
        end
    end

    task automatic wr_start(input bit v);
        @(negedge clk); start_wr = 1; start_wdata = v;
        @(negedge clk); start_wr = 0;
    endtask
    task automatic pulse_rd();
        @(negedge clk); flag_rd = 1;
        @(negedge clk); flag_rd = 0;
    endtask
    task automatic pulse_wr0();
        @(negedge clk); flag_wr0 = 1;
        @(negedge clk); flag_wr0 = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic stop_and_drain();
        wr_start(0);
        idle(LAT + 4);
    endtask

    initial begin
        int c0, s0;
        idle(3);
        cmp("R1 reset conv_start", conv_start, 0);
        cmp("R5 reset flag", flag_o, 0);
        cmp("R11 reset irq", irq_o, 0);
        rst_n = 1;
        idle(2);

        // R1: mode 00 never converts
        mode = 2'b00; cnt_sel = 2'd3;
        c0 = n_conv;
        wr_start(1);
        idle(30);
        cmp("R1 mode 00 conversions", n_conv - c0, 0);
        stop_and_drain();

        // R1/R6: one group, all four channels, repeating
        mode = 2'b01; cnt_sel = 2'd3; irq_en = 1;
        c0 = n_conv; s0 = n_sets; first_ch = -1;
        wr_start(1);
        idle(120);
        cmp("R2 first channel", first_ch, 0);
        cmp("R6 scan repeats (conversions > 8)", int'(n_conv - c0 > 8), 1);
        cmp("R5 flag sets per group", int'(n_sets - s0 >= 2), 1);
        // R9: write 0 without read keeps flag
        @(negedge clk); flag_wr0 = 1;
        @(negedge clk); flag_wr0 = 0;
        cmp("R9 unarmed write keeps flag", flag_o, 1);
        stop_and_drain();
        pulse_wr0();
        pulse_rd();
        pulse_wr0();
        idle(1);
        cmp("R9 read then write clears", flag_o, 0);
        cmp("R11 irq clears with flag", irq_o, 0);

        // R3: mode 10, k=2 -> 0,1,2,4,5,6
        mode = 2'b10; cnt_sel = 2'd2; irq_en = 0;
        c0 = n_conv; first_ch = -1;
        wr_start(1);
        idle(150);
        cmp("R7 restart from 0", first_ch, 0);
        cmp("R11 irq masked", irq_o, 0);
        irq_en = 1;
        idle(30);

        // R10 and set-wins: hold DMA ack across several group ends
        s0 = n_sets;
        @(negedge clk); dma_ack = 1;
        idle(80);
        @(negedge clk); dma_ack = 0;
        cmp("R11 sets seen during dma hold", int'(n_sets - s0 >= 2), 1);
        idle(2);
        pulse_rd();
        @(negedge clk); dma_ack = 1;
        @(negedge clk); dma_ack = 0;
        idle(1);

        // R8: abort right after a start pulse
        @(negedge clk);
        while (!conv_start) @(negedge clk);
        start_wr = 1; start_wdata = 0;
        @(negedge clk); start_wr = 0;
        c0 = n_conv;
        idle(20);
        cmp("R8 no start after abort", n_conv - c0, 0);

        // R1/R7: mode 11, k=0 -> 0,4,8; restart from 0
        mode = 2'b11; cnt_sel = 2'd0; first_ch = -1;
        wr_start(1);
        idle(90);
        cmp("R7 first channel after restart", first_ch, 0);

        // R8: stop in the cycle of a done pulse
        @(negedge clk);
        while (resp_cnt != 1) @(negedge clk);
        start_wr = 1; start_wdata = 0;
        @(negedge clk); start_wr = 0;
        c0 = n_conv;
        idle(20);
        cmp("R8 stop on done issues no start", n_conv - c0, 0);
        first_ch = -1;
        mode = 2'b10; cnt_sel = 2'd1;
        wr_start(1);
        idle(80);
        cmp("R7 resume at channel 0", first_ch, 0);
        stop_and_drain();

        done_run = 1;
        summary();
    end
endmodule